// File: doc/BRIEF.md
# Serial Port Peripheral with Byte Register Bus and FIFOs

This block is an asynchronous serial transmitter/receiver that software controls through an 8-bit register bus. The bus has an address, a write strobe, a read strobe and read/write data lines. There is one data address. A write to it queues a byte for transmission. A read from it removes the oldest received byte. Each direction has a 16-entry FIFO. Each receive entry keeps its own parity, framing and overrun flags. The line status register shows the flags of the byte most recently removed, so software reads the data address first and then the status.

Bit timing comes from an oversampling tick. The tick divides the clock by a 16-bit divisor plus one, and one serial bit lasts 16 ticks. The frame format can be changed at run time:
- 7 or 8 data bits
- optional even or odd parity
- one or two stop bits

The block exports two interrupt conditions for a separate interrupt-flag block:
- The receive condition asserts above a programmable fill threshold. That threshold is never below half the FIFO.
- The transmit condition asserts when the transmit FIFO is almost empty.

Top module: `uart_regport`

Register map (4-bit address):

| Offset | Register |
|---|---|
| 0x0 | enable |
| 0x1 | control |
| 0x2 | line status |
| 0x3 | line format |
| 0x4 | data |
| 0x8 | divisor low |
| 0x9 | divisor high |
| 0xA | FIFO status |
| 0xB | FIFO config |

## Requirements
- R1: Writable registers read back their implemented bits at their offsets:
  - enable bit 0
  - control bits 2:0
  - format bits 0, 1, 2 and 4
  - divisor low and high
  - FIFO config bits 3:0 and 7
- R14: A read returns its data on `rd_data` in the cycle after `rd_en`.
- R2: A write to offset 0x4 pushes a byte into the transmit FIFO. A read from offset 0x4 pops one byte from the receive FIFO and returns it. A pop with the FIFO empty changes no FIFO state.
- R3: Frame format on `txd`:
  - idle high, then a low start bit
  - data LSB first: 8 bits when format bit 0 is 1, 7 bits when it is 0
  - a parity bit when format bit 2 is 1: even parity, or odd when format bit 4 is 1
  - one stop bit, or two when format bit 1 is 1
  - each bit lasts 16*(divisor+1) clocks
- R4: The receiver checks the start bit 8 ticks after it sees the line low. If the line is high at that point, the receiver returns to idle and stores nothing.
- R5: Each received byte is stored with its error flags. Status bit 0 is set on a parity mismatch and bit 1 on a zero stop bit. Status bits 2:0 show the flags of the byte most recently popped. In 7-bit mode, data bit 7 reads 0.
- R6: When a byte completes while the receive FIFO is full, it is discarded. The overrun flag (status bit 2) is set on the newest stored entry.
- R7: Status bit 6 is 1 exactly when the transmitter is idle and the transmit FIFO is empty.
- R8: FIFO status bits:
  - bit 2: receive FIFO empty
  - bit 3: receive level above threshold
  - bit 4: transmit FIFO full
  - bit 7: transmit level below half depth

  `rx_irq` follows bit 3 and `tx_irq` follows bit 7, each one cycle later.
- R9: The receive condition is true when the fill level exceeds 8 plus FIFO config bits 2:0.
- R10: When FIFO config bit 7 (transmit) or bit 3 (receive) is 0, that FIFO holds one entry. A push to it while full is dropped.
- R11: With enable bit 0 cleared, `txd` stays high, no frame starts and no byte is received. Queued bytes wait until enable is set again.
- R12: While control bit 2 is set, both FIFOs are emptied and both serial engines are held idle with `txd` high.
- R13: Control bit 0 gates the start of reception and control bit 1 gates the start of transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| tx_irq | output | 1 | Transmit FIFO almost-empty condition |
| rx_irq | output | 1 | Receive FIFO above-threshold condition |

## Verification
The bound checker watches the cycle-level invariants:
- soft reset and disable drive `txd` high and (for soft reset) empty both FIFOs in the next cycle
- the receive level never exceeds the depth
- every asserted `rx_irq` follows a level above half depth
- a data-address pop of a non-empty receive FIFO lowers its level by exactly one

The rest can only be shown by the bench's scenarios:
- frame formats on the wire
- parity and framing flags tied to the right byte
- the overrun mark on the newest entry
- false-start rejection
- threshold settings
- single-entry FIFO behaviour
- bytes held back while the peripheral is disabled

// File: rtl/uart_regport_pkg.sv
package uart_regport_pkg;
  localparam logic [3:0] OFS_ENABLE = 4'h0;
  localparam logic [3:0] OFS_CTRL   = 4'h1;
  localparam logic [3:0] OFS_STATUS = 4'h2;
  localparam logic [3:0] OFS_FORMAT = 4'h3;
  localparam logic [3:0] OFS_DATA   = 4'h4;
  localparam logic [3:0] OFS_DIV_LO = 4'h8;
  localparam logic [3:0] OFS_DIV_HI = 4'h9;
  localparam logic [3:0] OFS_FSTAT  = 4'hA;
  localparam logic [3:0] OFS_FCFG   = 4'hB;

  // packed order gives parity at bit 0, framing bit 1, overrun bit 2
  typedef struct packed {
    logic ovr;
    logic frm;
    logic par;
  } rx_flags_t;

  typedef struct packed {
    logic eight;
    logic two_stop;
    logic par_en;
    logic par_odd;
  } line_fmt_t;
endpackage

// File: rtl/uart_regport_fifo.sv
module uart_regport_fifo #(
  parameter int          W         = 8,
  parameter int          DEPTH     = 16,
  parameter logic [W-1:0] MARK_MASK = '0,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          one_deep,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  input  logic          mark,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = one_deep ? (count != '0) : (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
    if (mark && !empty) mem[AW'(wp - 1'b1)] <= mem[AW'(wp - 1'b1)] | MARK_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/uart_regport_tx.sv
module uart_regport_tx
  import uart_regport_pkg::*;
#(
  parameter int OSR = 16,
  localparam int TW = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       tick,
  input  logic       go_en,
  input  logic       have_data,
  input  logic [7:0] data,
  input  line_fmt_t  fmt,
  output logic       pop,
  output logic       txd,
  output logic       busy
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;
  tx_st_t    st;
  logic [TW-1:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] sh;
  line_fmt_t  lfmt;
  logic       par_b, second;
  logic [2:0] last;

  assign last = lfmt.eight ? 3'd7 : 3'd6;
  assign pop  = (st == T_IDLE) && tick && go_en && have_data && !hold;
  assign busy = (st != T_IDLE);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st     <= T_IDLE;
      txd    <= 1'b1;
      tcnt   <= '0;
      bidx   <= '0;
      second <= 1'b0;
      sh     <= '0;
      par_b  <= 1'b0;
      lfmt   <= '0;
    end else if (st == T_IDLE) begin
      if (pop) begin
        sh    <= data;
        lfmt  <= fmt;
        par_b <= ^(data & (fmt.eight ? 8'hFF : 8'h7F)) ^ fmt.par_odd;
        st    <= T_START;
        txd   <= 1'b0;
        tcnt  <= '0;
      end
    end else if (tick) begin
      if (tcnt != TW'(OSR - 1)) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        case (st)
          T_START: begin
            st   <= T_DATA;
            txd  <= sh[0];
            bidx <= '0;
          end
          T_DATA: begin
            if (bidx == last) begin
              second <= 1'b0;
              if (lfmt.par_en) begin
                st  <= T_PAR;
                txd <= par_b;
              end else begin
                st  <= T_STOP;
                txd <= 1'b1;
              end
            end else begin
              bidx <= bidx + 1'b1;
              sh   <= sh >> 1;
              txd  <= sh[1];
            end
          end
          T_PAR: begin
            st  <= T_STOP;
            txd <= 1'b1;
          end
          default: begin
            if (lfmt.two_stop && !second) second <= 1'b1;
            else                          st     <= T_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regport_rx.sv
module uart_regport_rx
  import uart_regport_pkg::*;
#(
  parameter int OSR = 16,
  localparam int TW = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       tick,
  input  logic       go_en,
  input  logic       rxd,
  input  line_fmt_t  fmt,
  output logic       vld,
  output logic [7:0] data,
  output logic       perr,
  output logic       ferr
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_t;
  rx_st_t    st;
  logic [TW-1:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] sh;
  logic       acc, pbad;
  logic [1:0] sync;
  logic       line;
  line_fmt_t  lfmt;

  assign line = sync[1];

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st   <= R_IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      acc  <= 1'b0;
      pbad <= 1'b0;
      vld  <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
      lfmt <= '0;
    end else begin
      vld <= 1'b0;
      if (tick) begin
        case (st)
          R_IDLE: if (go_en && !line) begin
            st   <= R_START;
            tcnt <= '0;
            lfmt <= fmt;
          end
          R_START: begin
            if (tcnt != TW'(OSR / 2 - 1)) begin
              tcnt <= tcnt + 1'b1;
            end else if (line) begin
              st <= R_IDLE;
            end else begin
              st   <= R_DATA;
              tcnt <= '0;
              bidx <= '0;
              acc  <= 1'b0;
              pbad <= 1'b0;
            end
          end
          default: begin
            if (tcnt != TW'(OSR - 1)) begin
              tcnt <= tcnt + 1'b1;
            end else begin
              tcnt <= '0;
              case (st)
                R_DATA: begin
                  sh   <= {line, sh[7:1]};
                  acc  <= acc ^ line;
                  bidx <= bidx + 1'b1;
                  if (bidx == (lfmt.eight ? 3'd7 : 3'd6))
                    st <= lfmt.par_en ? R_PAR : R_STOP;
                end
                R_PAR: begin
                  pbad <= line ^ acc ^ lfmt.par_odd;
                  st   <= R_STOP;
                end
                default: begin
                  vld  <= 1'b1;
                  data <= lfmt.eight ? sh : {1'b0, sh[7:1]};
                  perr <= pbad;
                  ferr <= !line;
                  st   <= R_IDLE;
                end
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regport.sv
module uart_regport
  import uart_regport_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       txd,
  input  logic       rxd,
  output logic       tx_irq,
  output logic       rx_irq
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;
  localparam int RXW  = 11;

  logic             en_q;
  logic [2:0]       ctrl_q;
  logic [7:0]       fmt_q, fcfg_q;
  logic [DIV_W-1:0] div_q, bcnt;
  logic             tick;
  rx_flags_t        last_flags;
  logic             srst, hold;
  line_fmt_t        fmt;

  logic             tx_pop, tx_full, tx_empty, tx_busy;
  logic [7:0]       tx_head;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             rx_vld, rx_perr, rx_ferr, rx_full, rx_empty;
  logic [7:0]       rx_byte;
  logic [RXW-1:0]   rx_head;
  logic             tx_push, rd_pop, rx_push, rx_mark;
  logic             tx_low, rx_above, tx_idle;

  assign srst    = ctrl_q[2];
  assign hold    = srst || !en_q;
  assign fmt     = '{eight: fmt_q[0], two_stop: fmt_q[1], par_en: fmt_q[2], par_odd: fmt_q[4]};
  assign tx_push = wr_en && (addr == OFS_DATA) && !srst;
  assign rd_pop  = rd_en && (addr == OFS_DATA);
  assign rx_push = rx_vld && !rx_full;
  assign rx_mark = rx_vld && rx_full;
  assign tx_low  = int'(tx_cnt) < HALF;
  assign rx_above = int'(rx_cnt) > HALF + int'(fcfg_q[2:0]);
  assign tx_idle = !tx_busy && tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ctrl_q <= '0;
      fmt_q  <= '0;
      fcfg_q <= '0;
      div_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_ENABLE: en_q   <= wr_data[0];
        OFS_CTRL:   ctrl_q <= wr_data[2:0];
        OFS_FORMAT: fmt_q  <= wr_data & 8'h17;
        OFS_FCFG:   fcfg_q <= wr_data & 8'h8F;
        OFS_DIV_LO: div_q[7:0] <= wr_data;
        OFS_DIV_HI: div_q[DIV_W-1:8] <= wr_data[DIV_W-9:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      bcnt <= '0;
      tick <= 1'b0;
    end else if (bcnt == div_q) begin
      bcnt <= '0;
      tick <= 1'b1;
    end else begin
      bcnt <= bcnt + 1'b1;
      tick <= 1'b0;
    end
  end

  uart_regport_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(srst), .one_deep(!fcfg_q[7]),
    .push(tx_push), .wdata(wr_data), .pop(tx_pop), .mark(1'b0),
    .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  uart_regport_fifo #(.W(RXW), .DEPTH(DEPTH), .MARK_MASK(RXW'(1) << 10)) u_rxq (
    .clk(clk), .rst(rst), .clr(srst), .one_deep(!fcfg_q[3]),
    .push(rx_push), .wdata({1'b0, rx_ferr, rx_perr, rx_byte}), .pop(rd_pop),
    .mark(rx_mark), .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  uart_regport_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .hold(hold), .tick(tick), .go_en(ctrl_q[1]),
    .have_data(!tx_empty), .data(tx_head), .fmt(fmt), .pop(tx_pop),
    .txd(txd), .busy(tx_busy));

  uart_regport_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .hold(hold), .tick(tick), .go_en(ctrl_q[0]),
    .rxd(rxd), .fmt(fmt), .vld(rx_vld), .data(rx_byte), .perr(rx_perr),
    .ferr(rx_ferr));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      last_flags <= '0;
      tx_irq     <= 1'b0;
      rx_irq     <= 1'b0;
    end else begin
      tx_irq <= tx_low;
      rx_irq <= rx_above;
      if (rd_pop && !rx_empty) last_flags <= rx_head[10:8];
      if (rd_en) begin
        case (addr)
          OFS_ENABLE: rd_data <= {7'b0, en_q};
          OFS_CTRL:   rd_data <= {5'b0, ctrl_q};
          OFS_STATUS: rd_data <= {1'b0, tx_idle, 3'b0, last_flags};
          OFS_FORMAT: rd_data <= fmt_q;
          OFS_DATA:   rd_data <= rx_head[7:0];
          OFS_DIV_LO: rd_data <= div_q[7:0];
          OFS_DIV_HI: rd_data <= 8'(div_q[DIV_W-1:8]);
          OFS_FSTAT:  rd_data <= {tx_low, 2'b0, tx_full, rx_above, rx_empty, 2'b0};
          OFS_FCFG:   rd_data <= fcfg_q;
          default:    rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regport_chk.sv
module uart_regport_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          txd,
  input logic          rx_irq,
  input logic          en,
  input logic          srst,
  input logic          rd_pop,
  input logic          rx_push,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt
);
  a_r12_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
    srst |=> (tx_cnt == '0 && rx_cnt == '0 && txd));

  a_r11_disabled_line_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> txd);

  a_r6_rx_level_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(rx_cnt) <= DEPTH);

  a_r9_irq_above_half: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> int'($past(rx_cnt)) > DEPTH / 2);

  a_r2_pop_lowers_level: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && rx_cnt != '0 && !rx_push && !srst) |=> (rx_cnt == $past(rx_cnt) - 1'b1));
endmodule

bind uart_regport uart_regport_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .txd(txd), .rx_irq(rx_irq), .en(en_q), .srst(srst),
  .rd_pop(rd_pop), .rx_push(rx_push), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt));

// File: tb/uart_regport_tb.sv
module uart_regport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       txd, rxd, tx_irq, rx_irq;
  logic       loop = 1'b0, rxd_drv = 1'b1;
  int         checks = 0, errors = 0;
  int         m_bits = 8;
  bit         m_par = 0, m_odd = 0;
  logic [7:0] exp_q[$];

  assign rxd = loop ? txd : rxd_drv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_regport u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .txd(txd), .rxd(rxd),
    .tx_irq(tx_irq), .rx_irq(rx_irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R14: data appears in the cycle after the strobe
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: queue expected byte, then write it to the data address
  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(b);
    wr(4'h4, b);
  endtask

  task automatic ser_send(input logic [7:0] b, input bit flip_par, input bit stop_low);
    logic p;
    p = 1'b0;
    @(negedge clk);
    rxd_drv = 1'b0;
    idle(BITC);
    for (int i = 0; i < m_bits; i++) begin
      rxd_drv = b[i];
      p = p ^ b[i];
      idle(BITC);
    end
    if (m_par) begin
      rxd_drv = p ^ m_odd ^ flip_par;
      idle(BITC);
    end
    if (stop_low) begin
      rxd_drv = 1'b0;
      idle(10);
      rxd_drv = 1'b1;
      idle(40);
    end else begin
      rxd_drv = 1'b1;
      idle(BITC + 32);
    end
  endtask

  // monitor: decode frames on txd and compare with the scoreboard queue
  initial begin
    logic [7:0] got, e, msk;
    logic pb, sb;
    forever begin
      @(negedge txd);
      idle(BITC / 2);
      chk("R3 start bit low", txd, 0);
      got = '0;
      for (int i = 0; i < m_bits; i++) begin
        idle(BITC);
        got[i] = txd;
      end
      pb = 1'b0;
      if (m_par) begin
        idle(BITC);
        pb = txd;
      end
      idle(BITC);
      sb = txd;
      msk = (m_bits == 8) ? 8'hFF : 8'h7F;
      if (exp_q.size() == 0) begin
        chk("R3 unexpected frame", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk("R3 frame data", got, e & msk);
        if (m_par) chk("R3 parity bit", pb, (^(e & msk)) ^ m_odd);
        chk("R3 stop bit", sb, 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(5);
    rst = 1'b0;
    idle(3);
    rd(4'hA, d); chk("R8 reset FIFO status", d, 8'h84);
    rd(4'h2, d); chk("R7 reset line status", d, 8'h40);
    chk("R8 reset tx_irq", tx_irq, 1);
    chk("R8 reset rx_irq", rx_irq, 0);

    wr(4'h0, 8'h01); wr(4'h8, 8'h00); wr(4'h9, 8'h00);
    wr(4'hB, 8'h88); wr(4'h3, 8'h01); wr(4'h1, 8'h03);
    rd(4'h3, d); chk("R1 format readback", d, 8'h01);
    rd(4'hB, d); chk("R1 FIFO config readback", d, 8'h88);
    rd(4'h1, d); chk("R1 control readback", d, 8'h03);

    // 8N1 loopback
    loop = 1'b1;
    send_tx(8'hA5); send_tx(8'h3C);
    idle(450);
    rd(4'h4, d); chk("R2 first popped byte", d, 8'hA5);
    rd(4'h2, d); chk("R5 clean status after pop", d, 8'h40);
    rd(4'h4, d); chk("R2 second popped byte", d, 8'h3C);
    rd(4'hA, d); chk("R2 rx empty after pops", d, 8'h84);

    // 7 bits, even parity, two stop bits
    wr(4'h3, 8'h06); m_bits = 7; m_par = 1; m_odd = 0;
    send_tx(8'hD5); send_tx(8'h7F);
    idle(500);
    rd(4'h4, d); chk("R5 7-bit data bit7 zero", d, 8'h55);
    rd(4'h2, d); chk("R5 no error 7E2", d & 8'h07, 0);
    rd(4'h4, d); chk("R3 7E2 second byte", d, 8'h7F);

    // 8 bits, odd parity, one stop
    wr(4'h3, 8'h15); m_bits = 8; m_odd = 1;
    send_tx(8'h00); send_tx(8'h81);
    idle(450);
    rd(4'h4, d); chk("R3 8O1 first", d, 8'h00);
    rd(4'h4, d); chk("R3 8O1 second", d, 8'h81);
    rd(4'h2, d); chk("R5 no error 8O1", d & 8'h07, 0);

    // parity and framing errors injected on the line
    loop = 1'b0;
    ser_send(8'h42, 1'b1, 1'b0);
    rd(4'h4, d); chk("R5 parity-error byte", d, 8'h42);
    rd(4'h2, d); chk("R5 parity flag", d & 8'h07, 1);
    ser_send(8'h99, 1'b0, 1'b1);
    rd(4'h4, d); chk("R5 framing-error byte", d, 8'h99);
    rd(4'h2, d); chk("R5 framing flag", d & 8'h07, 2);

    // false start
    @(negedge clk); rxd_drv = 1'b0; idle(5); rxd_drv = 1'b1; idle(60);
    rd(4'hA, d); chk("R4 false start ignored", d, 8'h84);

    // threshold and overrun, 8N1
    wr(4'h3, 8'h01); m_par = 0; m_odd = 0;
    for (int i = 0; i < 8; i++) ser_send(8'(i), 1'b0, 1'b0);
    chk("R9 level 8 below threshold", rx_irq, 0);
    ser_send(8'd8, 1'b0, 1'b0);
    chk("R9 level 9 above threshold", rx_irq, 1);
    rd(4'hA, d); chk("R8 above-threshold bit", d & 8'h08, 8'h08);
    for (int i = 9; i < 16; i++) ser_send(8'(i), 1'b0, 1'b0);
    ser_send(8'hEE, 1'b0, 1'b0);
    wr(4'hB, 8'h8F);
    idle(2);
    chk("R9 thresh 7 level 16", rx_irq, 1);
    for (int i = 0; i < 16; i++) begin
      rd(4'h4, d); chk("R6 stored order", d, i);
      rd(4'h2, d);
      if (i == 0) begin
        chk("R6 older entry no overrun", d & 8'h07, 0);
        idle(2);
        chk("R9 thresh 7 level 15", rx_irq, 0);
      end
      if (i == 15) chk("R6 overrun on newest entry", d & 8'h07, 4);
    end
    rd(4'hA, d); chk("R6 dropped byte absent", d & 8'h04, 8'h04);

    // single-entry FIFOs, transmitter gated off
    wr(4'h1, 8'h01); wr(4'hB, 8'h00);
    wr(4'h4, 8'h11);
    rd(4'hA, d); chk("R10 tx full at one entry", d, 8'h94);
    wr(4'h4, 8'h22);
    idle(50);
    chk("R13 tx gated keeps line high", txd, 1);
    exp_q.push_back(8'h11);
    loop = 1'b1;
    wr(4'h1, 8'h03);
    idle(300);
    rd(4'h4, d); chk("R10 only first byte kept", d, 8'h11);
    rd(4'hA, d); chk("R10 second byte dropped", d, 8'h84);

    // peripheral disabled
    wr(4'hB, 8'h88); wr(4'h0, 8'h00);
    wr(4'h4, 8'h33);
    idle(200);
    chk("R11 disabled line high", txd, 1);
    rd(4'h2, d); chk("R7 busy while byte queued", d & 8'h40, 0);
    exp_q.push_back(8'h33);
    wr(4'h0, 8'h01);
    idle(300);
    rd(4'h4, d); chk("R11 sent after enable", d, 8'h33);

    // soft reset
    wr(4'h1, 8'h01);
    wr(4'h4, 8'h44); wr(4'h4, 8'h45);
    loop = 1'b0;
    ser_send(8'h66, 1'b0, 1'b0);
    rd(4'hA, d); chk("R12 before soft reset", d, 8'h80);
    wr(4'h1, 8'h04); wr(4'h1, 8'h03);
    rd(4'hA, d); chk("R12 FIFOs emptied", d, 8'h84);
    rd(4'h2, d); chk("R12 transmitter idle", d, 8'h40);
    idle(100);
    chk("R12 line high", txd, 1);

    chk("R3 all frames seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule